// File: doc/BRIEF.md
# Sticky Floating-Point Exception Flag Register

This block keeps the accumulated floating-point exception flags of a processor status word. Any number of floating-point units can report flags through their own update ports. Each port has a valid strobe, a guard bit and a seven-bit flag vector. A port's flags count only when the port is valid and its guard is 1. In that case they are merged into the held value on the same clock edge that writes back the producing result. Once a flag is set, it stays set until software writes the field explicitly.

All qualified updates that arrive in one cycle are ORed with each other and with the held value. The explicit write port loads the whole field. When the write coincides with hardware updates, the written value is ORed with that cycle's updates, so an exception raised in that cycle is never lost. The current field drives an output continuously.

Top module: `fpx_sticky_flags`

## Requirements
- R1: After reset (active-low `rst_n`), every flag reads 0.
- R2: A port with `upd_valid`=1 and `upd_guard`=1 sets each flag bit that is 1 in its vector. Bits already set stay set. No update can clear a bit.
- R3: In a cycle with no qualified update and no explicit write, the flag field keeps its value.
- R4: A port whose guard bit is 0 has no effect on any flag, even when its strobe is 1.
- R5: A port whose valid strobe is 0 has no effect on any flag, even when its guard is 1.
- R6: When several ports are qualified in the same cycle, each new flag bit is the OR of all their vectors with the held bit.
- R7: `sw_wr_en`=1 loads `sw_wr_data` into the whole field, which clears any bit written as 0. This write is the only way to clear a flag.
- R8: If an explicit write and qualified updates fall in the same cycle, the new field is `sw_wr_data` ORed with those updates.
- R9: An update or write drives its inputs during one cycle and appears on `flags_q` just after the next rising edge, not before.
- R10: The field layout is: bit 0 invalid, bit 1 overflow, bit 2 underflow, bit 3 divide-by-zero, bit 4 inexact, bit 5 input-flushed, bit 6 output-flushed. Port i drives bits [7i+6:7i] of `upd_flags`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all flags |
| upd_valid | input | N_PORTS | Per-port update strobe |
| upd_guard | input | N_PORTS | Per-port guard LSB; 0 suppresses the update |
| upd_flags | input | N_PORTS*7 | Packed per-port flag vectors, port i at bits [7i+6:7i] |
| sw_wr_en | input | 1 | Explicit status-write enable |
| sw_wr_data | input | 7 | Value loaded by the explicit write |
| flags_q | output | 7 | Current sticky flag field |

## Verification
Single-port updates that name one flag at a time show both that the bit positions are right and that bits accumulate instead of replacing each other. Some patterns hold the strobe high with the guard low, or the guard high with the strobe low. These separate the two qualifiers, so dropping either one is caught. A cycle with three qualified ports and one disqualified port shows the OR across ports. Writes of zero, plain writes, and writes that coincide with updates separate the load path from the merge path. Sampling just before and just after the edge pins the one-cycle latency.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W = 7;

  localparam int IDX_INVALID = 0;
  localparam int IDX_OVERFLOW = 1;
  localparam int IDX_UNDERFLOW = 2;
  localparam int IDX_DIV_ZERO = 3;
  localparam int IDX_INEXACT = 4;
  localparam int IDX_IN_FLUSH = 5;
  localparam int IDX_OUT_FLUSH = 6;

  typedef logic [FLAG_W-1:0] fpx_flags_t;

  // Flags a port contributes: all of them when qualified, none otherwise.
  function automatic fpx_flags_t gate_flags(input logic valid, input logic guard,
                                            input fpx_flags_t flags);
    return (valid && guard) ? flags : '0;
  endfunction

  // Next field: write value or held value, ORed with merged updates.
  function automatic fpx_flags_t next_field(input fpx_flags_t held, input logic wr_en,
                                            input fpx_flags_t wr_data,
                                            input fpx_flags_t merged);
    return (wr_en ? wr_data : held) | merged;
  endfunction
endpackage

// File: rtl/fpx_port_qual.sv
module fpx_port_qual
  import fpx_pkg::*;
(
  input  logic       valid,
  input  logic       guard,
  input  fpx_flags_t flags,
  output logic       live,
  output fpx_flags_t qual_flags
);
  assign live = valid & guard;
  assign qual_flags = gate_flags(valid, guard, flags);
endmodule

// File: rtl/fpx_flag_merge.sv
module fpx_flag_merge
  import fpx_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic [N_PORTS*FLAG_W-1:0] qual_flags,
  output fpx_flags_t                merged
);
  always_comb begin
    merged = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      merged = merged | qual_flags[i*FLAG_W +: FLAG_W];
    end
  end
endmodule

// File: rtl/fpx_flag_reg.sv
module fpx_flag_reg
  import fpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  fpx_flags_t wr_data,
  input  fpx_flags_t merged,
  output fpx_flags_t flags_q
);
  fpx_flags_t flags_d;

  assign flags_d = next_field(flags_q, wr_en, wr_data, merged);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // Without a write, no held bit may drop.
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // Idle cycle keeps the field.
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && merged == '0) |=> $stable(flags_q));

  // A write sets every bit it carries.
  assert_write_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flags_q & $past(wr_data)) == $past(wr_data)));

  // During a write, bits outside the written value come only from updates.
  assert_write_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flags_q & ~$past(wr_data)) == ($past(merged) & ~$past(wr_data))));
endmodule

// File: rtl/fpx_sticky_flags.sv
module fpx_sticky_flags
  import fpx_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        upd_valid,
  input  logic [N_PORTS-1:0]        upd_guard,
  input  logic [N_PORTS*FLAG_W-1:0] upd_flags,
  input  logic                      sw_wr_en,
  input  logic [FLAG_W-1:0]         sw_wr_data,
  output logic [FLAG_W-1:0]         flags_q
);
  localparam int BUS_W = N_PORTS * FLAG_W;

  logic [N_PORTS-1:0] port_live;
  logic [BUS_W-1:0]   port_qual;
  fpx_flags_t         merged_upd;
  fpx_flags_t         held;

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_port
    fpx_port_qual u_qual (
      .valid      (upd_valid[gi]),
      .guard      (upd_guard[gi]),
      .flags      (upd_flags[gi*FLAG_W +: FLAG_W]),
      .live       (port_live[gi]),
      .qual_flags (port_qual[gi*FLAG_W +: FLAG_W])
    );

    // Every qualified port's vector appears in the field after the edge.
    assert_port_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      port_live[gi] |=> ((flags_q & $past(upd_flags[gi*FLAG_W +: FLAG_W]))
                         == $past(upd_flags[gi*FLAG_W +: FLAG_W])));
  end

  fpx_flag_merge #(.N_PORTS(N_PORTS)) u_merge (
    .qual_flags (port_qual),
    .merged     (merged_upd)
  );

  fpx_flag_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sw_wr_en),
    .wr_data (sw_wr_data),
    .merged  (merged_upd),
    .flags_q (held)
  );

  assign flags_q = held;

  // Disqualified ports (guard or strobe low) must not move the field.
  assert_dropped_updates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((upd_valid & upd_guard) == '0) && !sw_wr_en) |=> $stable(flags_q));

  // The merged update carries nothing when no port is live.
  assert_no_live_no_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_live == '0) |-> (merged_upd == '0));
endmodule

// File: tb/tb_fpx_sticky_flags.sv
module tb_fpx_sticky_flags;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int W = 7;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            rst_n;
  logic [NP-1:0]   upd_valid;
  logic [NP-1:0]   upd_guard;
  logic [NP*W-1:0] upd_flags;
  logic            sw_wr_en;
  logic [W-1:0]    sw_wr_data;
  logic [W-1:0]    flags_q;

  fpx_sticky_flags #(.N_PORTS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_guard(upd_guard),
    .upd_flags(upd_flags), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .flags_q(flags_q)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] model;

  // Bit positions from R10
  localparam logic [W-1:0] F_INV = 7'h01, F_OVF = 7'h02, F_UNF = 7'h04,
    F_DBZ = 7'h08, F_INX = 7'h10, F_IFZ = 7'h20, F_OFZ = 7'h40;

  function automatic logic [NP*W-1:0] pack4(input logic [W-1:0] p0, p1, p2, p3);
    return {p3, p2, p1, p0};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (flags_q !== exp) begin
      n_fail++;
      $display("FAIL %s: flags_q=%h expected %h", req, flags_q, exp);
    end
  endtask

  task automatic idle_inputs();
    upd_valid = '0; upd_guard = '0; upd_flags = '0; sw_wr_en = 1'b0; sw_wr_data = '0;
  endtask

  // Drive one cycle, step past the edge, update the expected field.
  task automatic cycle(input logic [NP-1:0] v, input logic [NP-1:0] g,
                       input logic [NP*W-1:0] f, input logic we, input logic [W-1:0] wd);
    logic [W-1:0] u;
    upd_valid = v; upd_guard = g; upd_flags = f; sw_wr_en = we; sw_wr_data = wd;
    @(posedge clk); #1;
    u = '0;
    for (int i = 0; i < NP; i++) if (v[i] && g[i]) u = u | f[i*W +: W];
    model = (we ? wd : model) | u;
    idle_inputs();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle_inputs();
    @(posedge clk); #1;
    model = '0;
    chk("R1 reset", model);
    rst_n = 1'b1;
  endtask

  task automatic t_single();
    cycle(4'b0001, 4'b0001, pack4(F_INV, 0, 0, 0), 1'b0, '0);
    chk("R2/R10 invalid bit 0", model);
    cycle('0, '0, '0, 1'b0, '0);
    chk("R3 idle hold", model);
    cycle(4'b0100, 4'b0100, pack4(0, 0, F_DBZ, 0), 1'b0, '0);
    chk("R2/R10 divide-by-zero bit 3 sticky", model);
    cycle(4'b0001, 4'b0001, pack4(F_OVF, 0, 0, 0), 1'b0, '0);
    chk("R2 update cannot clear", model);
  endtask

  task automatic t_disqualified();
    cycle(4'b0010, 4'b0000, pack4(0, F_OVF | F_OFZ, 0, 0), 1'b0, '0);
    chk("R4 guard low ignored", model);
    cycle(4'b0000, 4'b1000, pack4(0, 0, 0, F_UNF | F_INX), 1'b0, '0);
    chk("R5 valid low ignored", model);
  endtask

  task automatic t_multi();
    cycle(4'b1111, 4'b1011, pack4(F_UNF, F_INX, F_OFZ, F_IFZ), 1'b0, '0);
    chk("R6 multi-port OR", model);
  endtask

  task automatic t_write();
    cycle('0, '0, '0, 1'b1, 7'h00);
    chk("R7 write clears", model);
    cycle('0, '0, '0, 1'b1, F_OFZ | F_INV);
    chk("R7 write loads", model);
    cycle(4'b1000, 4'b1000, pack4(0, 0, 0, F_OFZ | F_INV), 1'b1, F_OVF);
    chk("R8 write ORed with update", model);
    cycle(4'b0110, 4'b0010, pack4(0, F_DBZ, F_UNF, 0), 1'b1, '0);
    chk("R8 clear write with guarded update", model);
  endtask

  task automatic t_latency();
    upd_valid = 4'b0001; upd_guard = 4'b0001; upd_flags = pack4(F_INX, 0, 0, 0);
    #(CLK_PERIOD - 3);
    chk("R9 no change before edge", model);
    @(posedge clk); #1;
    model = model | F_INX;
    idle_inputs();
    chk("R9 visible after edge", model);
  endtask

  logic done = 1'b0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model = '0;
    rst_n = 1'b0; idle_inputs();
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    t_single();
    t_disqualified();
    t_multi();
    t_write();
    t_latency();
    cycle(4'b1111, 4'b1111, pack4(7'h7f, 0, 0, 0), 1'b0, '0);
    chk("R2 all flags set", model);
    t_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule